// File: doc/BRIEF.md
# Hysteretic Automatic Pause Generator

This block sits beside the receive buffer of a full-duplex Ethernet MAC. It watches the buffer's fill level and decides when the transmit side should send a PAUSE control frame. Two thresholds give it hysteresis. When the fill level climbs to the high mark, the block requests a PAUSE that carries a programmed pause time, counted in slot times. When the level later falls under the low mark, the block requests a second PAUSE whose time is zero. That zero-time frame tells the far end to resume at once.

The block does not build or send frames. It offers one request at a time on a valid/ready stream to the frame generator. `req_valid` stays high, and the request may not be withdrawn, until the generator accepts it with `req_ready`. While a high-mark request is waiting, its pause time stays fixed. There is one exception: if the fill level falls under the low mark before the high request is accepted, that request turns into the zero-time request in place. `req_valid` stays high through this swap. The generator may hold `req_ready` low for as long as it likes, and the block never drops a pending request on its own. The only thing that withdraws a request is clearing the enable.

Top module: `pause_gen_auto`

## Requirements
- R1: After reset, `req_valid` is 0.
- R2: With `fc_enable` set and no request outstanding, a fill level of `high_mark` or more raises `req_valid` in the following cycle. `req_quanta` then equals the `pause_time` value sampled on that edge.
- R3: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1. `req_quanta` keeps its value unless it is replaced by zero as in R6.
- R4: After a high request is accepted, no further request is raised while the fill level stays at or above `low_mark`, however high it climbs.
- R5: After a high request is accepted, a fill level strictly below `low_mark` raises `req_valid` in the following cycle with `req_quanta` = 0.
- R6: If the fill level is below `low_mark` while a high request is still waiting, the next cycle shows `req_valid` = 1 with `req_quanta` = 0.
- R7: Clearing `fc_enable` drops `req_valid` in the following cycle. Setting it again later does not produce a zero-time request, even with the fill level below `low_mark`.
- R8: The threshold comparisons are exact. A fill level equal to `high_mark` triggers. A fill level equal to `low_mark` does not count as below; `low_mark`-1 does.
- R9: Once a zero-time request is accepted, the block is armed again. The next fill level at or above `high_mark` raises a new high request.
- R10: With `fc_enable` clear, `req_valid` stays 0 for every fill level.
- R11: If a high request is accepted in the same cycle that the fill level is below `low_mark`, the next cycle shows a zero-time request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_enable | input | 1 | Enables automatic pause generation |
| fill_level | input | LVL_W | Current receive buffer occupancy |
| high_mark | input | LVL_W | Fill level at or above which a pause is requested |
| low_mark | input | LVL_W | Fill level below which a resume (zero-time) pause is requested |
| pause_time | input | TIME_W | Pause time, in slot times, for high-mark requests |
| req_valid | output | 1 | A pause request is offered |
| req_ready | input | 1 | The frame generator accepts the offered request |
| req_quanta | output | TIME_W | Pause time carried by the offered request |

## Verification
Two events can land on the same clock edge. One is the generator accepting a high request. The other is the fill level falling under the low mark, which calls for the resume request. The bench provokes this collision in a directed step, raising `req_ready` and lowering the fill level together. It also hits the collision repeatedly during a sweep over every ordered threshold pair of a 4-bit configuration, where fill ramps up and down under several ready patterns. In every cycle, a requirement-level model in the bench predicts `req_valid` and `req_quanta`. The expected result of the collision is a zero-time request in the next cycle, with no lost handshake and no repeated high request.

// File: rtl/pause_gen_pkg.sv
package pause_gen_pkg;
  typedef enum logic [1:0] {
    PG_ARMED   = 2'd0,
    PG_HI_WAIT = 2'd1,
    PG_HELD    = 2'd2,
    PG_LO_WAIT = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pause_gen_cmp.sv
module pause_gen_cmp #(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] high_mark,
  input  logic [LVL_W-1:0] low_mark,
  output logic             at_high,
  output logic             below_low
);
  // high side inclusive, low side strict
  always_comb begin
    at_high   = (fill_level >= high_mark);
    below_low = (fill_level <  low_mark);
  end
endmodule

// File: rtl/pause_gen_ctrl.sv
module pause_gen_ctrl
  import pause_gen_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              at_high,
  input  logic              below_low,
  input  logic [TIME_W-1:0] pause_time,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [TIME_W-1:0] req_quanta
);
  localparam logic [TIME_W-1:0] ZERO_TIME = '0;

  pg_state_e         state_q, state_d;
  logic [TIME_W-1:0] time_q, time_d;
  logic              taken;

  assign req_valid = (state_q == PG_HI_WAIT) || (state_q == PG_LO_WAIT);
  assign taken     = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    time_d  = time_q;
    if (!enable) begin
      state_d = PG_ARMED;
    end else begin
      unique case (state_q)
        PG_ARMED: begin
          if (at_high) begin
            state_d = PG_HI_WAIT;
            time_d  = pause_time;
          end
        end
        PG_HI_WAIT: begin
          // a low crossing either follows the accepted frame or replaces it
          if (below_low)  state_d = PG_LO_WAIT;
          else if (taken) state_d = PG_HELD;
        end
        PG_HELD: begin
          if (below_low) state_d = PG_LO_WAIT;
        end
        PG_LO_WAIT: begin
          if (taken) state_d = PG_ARMED;
        end
        default: state_d = PG_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PG_ARMED;
      time_q  <= ZERO_TIME;
    end else begin
      state_q <= state_d;
      time_q  <= time_d;
    end
  end

  assign req_quanta = (state_q == PG_LO_WAIT) ? ZERO_TIME : time_q;
endmodule

// File: rtl/pause_gen_auto.sv
module pause_gen_auto #(
  parameter int LVL_W  = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_enable,
  input  logic [LVL_W-1:0]  fill_level,
  input  logic [LVL_W-1:0]  high_mark,
  input  logic [LVL_W-1:0]  low_mark,
  input  logic [TIME_W-1:0] pause_time,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [TIME_W-1:0] req_quanta
);
  logic at_high, below_low;

  pause_gen_cmp #(.LVL_W(LVL_W)) u_cmp (
    .fill_level (fill_level),
    .high_mark  (high_mark),
    .low_mark   (low_mark),
    .at_high    (at_high),
    .below_low  (below_low)
  );

  pause_gen_ctrl #(.TIME_W(TIME_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (fc_enable),
    .at_high    (at_high),
    .below_low  (below_low),
    .pause_time (pause_time),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .req_quanta (req_quanta)
  );
endmodule

// File: rtl/pause_gen_auto_chk.sv
module pause_gen_auto_chk #(
  parameter int LVL_W  = 8,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fc_enable,
  input logic [LVL_W-1:0]  fill_level,
  input logic [LVL_W-1:0]  low_mark,
  input logic              req_valid,
  input logic              req_ready,
  input logic [TIME_W-1:0] req_quanta
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_enable && req_valid && !req_ready) |=> req_valid);

  assert_stable_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_enable && req_valid && !req_ready) |=>
      (req_quanta == $past(req_quanta) || req_quanta == '0));

  assert_replace_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_enable && req_valid && !req_ready && fill_level < low_mark) |=>
      (req_valid && req_quanta == '0));

  assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_enable |=> !req_valid);
endmodule

bind pause_gen_auto pause_gen_auto_chk #(.LVL_W(LVL_W), .TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fc_enable  (fc_enable),
  .fill_level (fill_level),
  .low_mark   (low_mark),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_quanta (req_quanta)
);

// File: tb/pause_gen_auto_test.sv
module pause_gen_auto_test;
  localparam int LW = 4;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fc_enable = 1'b0;
  logic [LW-1:0] fill_level = '0;
  logic [LW-1:0] high_mark = '0;
  logic [LW-1:0] low_mark = '0;
  logic [TW-1:0] pause_time = '0;
  logic          req_ready = 1'b0;
  logic          req_valid;
  logic [TW-1:0] req_quanta;

  int checks = 0;
  int errors = 0;

  // requirement-level model: 0 armed, 1 high waiting, 2 paused, 3 resume waiting
  int            m_st = 0;
  logic [TW-1:0] m_time = '0;

  always #10 clk = ~clk;

  pause_gen_auto #(.LVL_W(LW), .TIME_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable), .fill_level(fill_level),
    .high_mark(high_mark), .low_mark(low_mark), .pause_time(pause_time),
    .req_valid(req_valid), .req_ready(req_ready), .req_quanta(req_quanta)
  );

  function automatic logic m_valid();
    return (m_st == 1) || (m_st == 3);
  endfunction

  function automatic logic [TW-1:0] m_q();
    return (m_st == 3) ? '0 : m_time;
  endfunction

  task automatic chk(input string tag, input logic v_act, input logic v_exp,
                     input logic [TW-1:0] q_act, input logic [TW-1:0] q_exp,
                     input logic cmp_q);
    checks++;
    if (v_act !== v_exp || (cmp_q && q_act !== q_exp)) begin
      errors++;
      $display("FAIL %s: valid=%b quanta=%h expected valid=%b quanta=%h",
               tag, v_act, q_act, v_exp, q_exp);
    end
  endtask

  // one clock: inputs already set, model advances with the DUT edge
  task automatic step();
    @(posedge clk);
    if (!rst_n || !fc_enable) m_st = 0;
    else begin
      case (m_st)
        0: if (fill_level >= high_mark) begin m_st = 1; m_time = pause_time; end
        1: if (fill_level < low_mark) m_st = 3; else if (req_ready) m_st = 2;
        2: if (fill_level < low_mark) m_st = 3;
        default: if (req_ready) m_st = 0;
      endcase
    end
    #5;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 reset", req_valid, 1'b0, req_quanta, '0, 1'b0);
    rst_n = 1'b1;
    high_mark = 4'd8; low_mark = 4'd4; pause_time = 16'h1234;
    fc_enable = 1'b1; fill_level = 4'd7;
    step();
    chk("R8 below high", req_valid, 1'b0, req_quanta, '0, 1'b0);
    fill_level = 4'd8; step();
    chk("R2 R8 high equal", req_valid, 1'b1, req_quanta, 16'h1234, 1'b1);
    fill_level = 4'd6; pause_time = 16'h0555; step(); step(); step();
    chk("R3 hold", req_valid, 1'b1, req_quanta, 16'h1234, 1'b1);
    req_ready = 1'b1; step(); req_ready = 1'b0;
    chk("R4 accepted", req_valid, 1'b0, req_quanta, '0, 1'b0);
    fill_level = 4'd15; step(); step();
    chk("R4 no repeat", req_valid, 1'b0, req_quanta, '0, 1'b0);
    fill_level = 4'd4; step();
    chk("R8 low equal", req_valid, 1'b0, req_quanta, '0, 1'b0);
    fill_level = 4'd3; step();
    chk("R5 resume", req_valid, 1'b1, req_quanta, '0, 1'b1);
    req_ready = 1'b1; step(); req_ready = 1'b0;
    fill_level = 4'd9; step();
    chk("R9 rearmed", req_valid, 1'b1, req_quanta, 16'h0555, 1'b1);
    fill_level = 4'd2; step();
    chk("R6 replaced", req_valid, 1'b1, req_quanta, '0, 1'b1);
    req_ready = 1'b1; step(); req_ready = 1'b0;
    fill_level = 4'd12; step();
    req_ready = 1'b1; fill_level = 4'd1; step(); req_ready = 1'b0;
    chk("R11 collision", req_valid, 1'b1, req_quanta, '0, 1'b1);
    req_ready = 1'b1; step(); req_ready = 1'b0;
    fill_level = 4'd10; step();
    fc_enable = 1'b0; step();
    chk("R7 disable drops", req_valid, 1'b0, req_quanta, '0, 1'b0);
    fill_level = 4'd15; step(); step();
    chk("R10 disabled high", req_valid, 1'b0, req_quanta, '0, 1'b0);
    fill_level = 4'd1; fc_enable = 1'b1; step(); step();
    chk("R7 no zero frame", req_valid, 1'b0, req_quanta, '0, 1'b0);

    // sweep every ordered threshold pair with ramped fill and varied ready
    for (int hi = 1; hi < 16; hi++) begin
      for (int lo = 0; lo < hi; lo++) begin
        fc_enable = 1'b0; step();
        high_mark = LW'(hi); low_mark = LW'(lo);
        fc_enable = 1'b1;
        for (int s = 0; s < 34; s++) begin
          fill_level = (s < 16) ? LW'(s) : (s < 32 ? LW'(31 - s) : 4'd0);
          pause_time = TW'(hi * 256 + lo * 16 + s);
          case ((hi + lo) % 3)
            0: req_ready = 1'b1;
            1: req_ready = (s % 3 == 0);
            default: req_ready = (s % 7 == 5);
          endcase
          if ((hi + lo) % 5 == 0 && s == 20) fc_enable = 1'b0;
          if (s == 22) fc_enable = 1'b1;
          step();
          chk("sweep R2 R3 R4 R5 R6 R9 R10 R11", req_valid, m_valid(),
              req_quanta, m_q(), m_valid());
        end
        req_ready = 1'b0;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule